// File: doc/BRIEF.md
# Fractional time-of-day counter

This block keeps a running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every system clock, while counting is enabled, it adds a programmable increment. The increment is a 64-bit fixed-point number of nanoseconds: 5 integer bits and 59 fraction bits. A hidden fraction accumulator carries into the nanoseconds, and the nanoseconds roll over into the seconds at one billion.

Software drives the block through a small write port. Two 32-bit words hold the increment. A control word holds a run bit and an increment-hold bit. Staging words hold a time value or an offset. An action word selects one operation on the live time: load it from the staging words, snapshot it into the snapshot outputs, or shift it by a signed nanosecond offset. The live time and the snapshot are both visible as outputs.

Top module: `tod_counter`

## Requirements
- R1: After reset the live time and the snapshot are all zero, counting is stopped, and the active increment is 0x304D4873ECADE305 (about 6.0377 ns per cycle).
- R2: On each clock with the run bit (control word, address 2, bit 0) set, the active increment is added to the nanoseconds plus the 59-bit fraction. Bits 63:59 of the increment are whole nanoseconds, and a carry out of the fraction adds one more nanosecond.
- R3: Nanoseconds always stay below 1,000,000,000. Reaching that value subtracts it and adds one to the seconds, and the seconds wrap modulo 2^48.
- R4: Writes to the increment words (address 0 low, address 1 high) are stored only while the hold bit (control word bit 1) is set, and are dropped otherwise. The stored words replace the active increment on the write that clears the hold bit. Until then counting keeps using the old value.
- R5: The action word is address 3, bits 2:0. Code 0 is idle, 1 is load, 2 is save and 4 is delta. Codes 3, 5, 6 and 7 have no effect and leave the held code unchanged.
- R6: A load or delta is carried out only when the previously accepted action code is idle. Otherwise the write has no effect.
- R7: A load copies the staged seconds (address 4 bits 15:0 as seconds 47:32, address 5 as seconds 31:0) and the staged nanoseconds (address 6 bits 29:0) into the live time, and clears the fraction. A staged nanoseconds value of 1,000,000,000 or more that is not a negative code makes the load write have no effect.
- R8: A staged nanoseconds value whose bits 29:4 are all ones is a small negative value. Loading it gives seconds minus one and nanoseconds equal to bits 3:0 plus 999,999,984.
- R9: A save write makes the snapshot outputs equal to the live time of that cycle, from the next cycle on. At all other times the snapshot holds its value.
- R10: A delta adds the staged nanoseconds, read as a 30-bit two's-complement number, to the live time. A result below zero borrows one second, and a result of one billion or more carries one second, within the same cycle.
- R11: A delta whose magnitude is 500,000,000 or more has no effect.
- R12: While the run bit is clear, the live time changes only through an accepted load or delta.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |
| snap_sec | output | 48 | Snapshot seconds |
| snap_ns | output | 30 | Snapshot nanoseconds |

## Verification
The delta path is tried with a table of start times and offsets:
- positive and negative offsets that stay inside the second;
- offsets that borrow from or carry into the seconds;
- offsets just inside the half-second limit in both directions;
- a zero offset;
- a carry that wraps the full 48-bit seconds.

Comparing these separates an ordinary add from the borrow and carry paths, and from a wrong sign extension. The counting path runs two increments over a thousand cycles and across the one-second rollover:
- the nominal increment, where the fraction carries matter;
- an exact one-nanosecond increment, where they do not.

Directed writes then probe the action rules: a load after a non-idle code, a reserved code, an out-of-range offset, a negative-coded load, an illegal nanosecond load, and increment writes with the hold bit clear. For each, the bench checks that the live time either moves or stays where it was.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int SEC_W     = 48;
    localparam int NS_W      = 30;
    localparam int INC_W     = 64;
    localparam int INC_INT_W = 5;
    localparam int FRAC_W    = INC_W - INC_INT_W;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int INC_WORDS = INC_W / DATA_W;
    localparam int SEC_HI_W  = SEC_W - DATA_W;
    localparam int NEG_LSB   = 4;

    localparam logic [INC_W-1:0] INC_NOMINAL = 64'h304D_4873_ECAD_E305;
    localparam logic [NS_W-1:0]  NS_PER_SEC  = 30'd1_000_000_000;
    localparam logic [NS_W-1:0]  DELTA_LIM   = 30'd500_000_000;

    typedef enum logic [2:0] {
        SLOT_IDLE  = 3'd0,
        SLOT_LOAD  = 3'd1,
        SLOT_SAVE  = 3'd2,
        SLOT_RSVD  = 3'd3,
        SLOT_DELTA = 3'd4
    } slot_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_INC_LO = 3'd0,
        REG_INC_HI = 3'd1,
        REG_CTRL   = 3'd2,
        REG_ACT    = 3'd3,
        REG_SEC_HI = 3'd4,
        REG_SEC_LO = 3'd5,
        REG_NS     = 3'd6
    } reg_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    function automatic logic ns_is_neg(input logic [NS_W-1:0] ns);
        return &ns[NS_W-1:NEG_LSB];
    endfunction

    function automatic logic ns_loadable(input logic [NS_W-1:0] ns);
        return (ns < NS_PER_SEC) || ns_is_neg(ns);
    endfunction

    function automatic tod_t fold_neg(input tod_t t);
        tod_t r;
        r = t;
        if (ns_is_neg(t.ns)) begin
            r.sec = t.sec - 1'b1;
            r.ns  = (NS_PER_SEC - NS_W'(16)) + NS_W'(t.ns[NEG_LSB-1:0]);
        end
        return r;
    endfunction

    function automatic logic delta_ok(input logic [NS_W-1:0] d);
        logic signed [NS_W-1:0] s;
        s = $signed(d);
        return (s < $signed(DELTA_LIM)) && (s > -$signed(DELTA_LIM));
    endfunction

endpackage

// File: rtl/tod_inc_cfg.sv
module tod_inc_cfg
    import tod_pkg::*;
#(
    parameter logic [INC_W-1:0] INC_RESET = INC_NOMINAL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INC_WORDS-1:0] wr_word,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 hold_q,
    input  logic                 release_hold,
    output logic [INC_W-1:0]     inc_act
);

    logic [INC_W-1:0] shadow;

    for (genvar w = 0; w < INC_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                shadow[w*DATA_W +: DATA_W] <= INC_RESET[w*DATA_W +: DATA_W];
            else if (hold_q && wr_word[w])
                shadow[w*DATA_W +: DATA_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            inc_act <= INC_RESET;
        else if (release_hold)
            inc_act <= shadow;
    end

endmodule

// File: rtl/tod_slot.sv
module tod_slot
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output tod_t              stage,
    output logic              do_load,
    output logic              do_save,
    output logic              do_delta
);

    slot_e held;
    slot_e code;
    logic  act_wr;
    logic  idle_wr;
    logic  held_idle;

    always_comb begin
        act_wr    = wr_en && (wr_addr == REG_ACT);
        code      = slot_e'(wr_data[2:0]);
        held_idle = (held == SLOT_IDLE);
        idle_wr   = act_wr && (code == SLOT_IDLE);
        do_save   = act_wr && (code == SLOT_SAVE);
        do_load   = act_wr && (code == SLOT_LOAD) && held_idle && ns_loadable(stage.ns);
        do_delta  = act_wr && (code == SLOT_DELTA) && held_idle && delta_ok(stage.ns);
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= SLOT_IDLE;
        else if (idle_wr || do_save || do_load || do_delta)
            held <= code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_SEC_HI: stage.sec[SEC_W-1:DATA_W] <= wr_data[SEC_HI_W-1:0];
                REG_SEC_LO: stage.sec[DATA_W-1:0]     <= wr_data;
                REG_NS:     stage.ns                  <= wr_data[NS_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tod_core.sv
module tod_core
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [INC_W-1:0] inc,
    input  logic             do_load,
    input  logic             do_save,
    input  logic             do_delta,
    input  tod_t             stage,
    output tod_t             live,
    output tod_t             snap
);

    localparam int SW = NS_W + 2;
    localparam logic signed [SW-1:0] LIM = SW'(NS_PER_SEC);

    logic [FRAC_W-1:0]      frac;
    logic [FRAC_W:0]        frac_sum;
    logic [INC_INT_W:0]     step;
    logic signed [SW-1:0]   base_ns;
    logic signed [SW-1:0]   delta_ext;
    logic signed [SW-1:0]   ns_sum;
    tod_t                   nxt;
    logic [FRAC_W-1:0]      frac_nxt;

    always_comb begin
        frac_sum  = {1'b0, frac} + {1'b0, inc[FRAC_W-1:0]};
        step      = {1'b0, inc[INC_W-1:FRAC_W]} + (INC_INT_W+1)'(frac_sum[FRAC_W]);
        base_ns   = $signed({2'b00, live.ns}) + (run ? $signed(SW'(step)) : '0);
        delta_ext = do_delta ? SW'($signed(stage.ns)) : '0;
        ns_sum    = base_ns + delta_ext;
        frac_nxt  = run ? frac_sum[FRAC_W-1:0] : frac;
        nxt.sec   = live.sec;
        if (ns_sum < 0) begin
            nxt.ns  = NS_W'(ns_sum + LIM);
            nxt.sec = live.sec - 1'b1;
        end else if (ns_sum >= LIM) begin
            nxt.ns  = NS_W'(ns_sum - LIM);
            nxt.sec = live.sec + 1'b1;
        end else begin
            nxt.ns  = NS_W'(ns_sum);
        end
        if (do_load) begin
            nxt      = fold_neg(stage);
            frac_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            frac <= '0;
            snap <= '0;
        end else begin
            live <= nxt;
            frac <= frac_nxt;
            if (do_save)
                snap <= live;
        end
    end

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter logic [INC_W-1:0] INC_RESET = INC_NOMINAL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns,
    output logic [SEC_W-1:0]  snap_sec,
    output logic [NS_W-1:0]   snap_ns
);

    logic                 run_q;
    logic                 hold_q;
    logic                 ctrl_wr;
    logic                 release_hold;
    logic [INC_WORDS-1:0] wr_word;
    logic [INC_W-1:0]     inc_act;
    tod_t                 stage;
    tod_t                 live;
    tod_t                 snap;
    logic                 do_load;
    logic                 do_save;
    logic                 do_delta;

    assign ctrl_wr      = wr_en && (wr_addr == REG_CTRL);
    assign release_hold = ctrl_wr && hold_q && !wr_data[1];

    for (genvar w = 0; w < INC_WORDS; w++) begin : g_sel
        assign wr_word[w] = wr_en && (wr_addr == ADDR_W'(int'(REG_INC_LO) + w));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
        end else if (ctrl_wr) begin
            run_q  <= wr_data[0];
            hold_q <= wr_data[1];
        end
    end

    tod_inc_cfg #(.INC_RESET(INC_RESET)) u_inc (
        .clk          (clk),
        .rst          (rst),
        .wr_word      (wr_word),
        .wdata        (wr_data),
        .hold_q       (hold_q),
        .release_hold (release_hold),
        .inc_act      (inc_act)
    );

    tod_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stage    (stage),
        .do_load  (do_load),
        .do_save  (do_save),
        .do_delta (do_delta)
    );

    tod_core u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .inc      (inc_act),
        .do_load  (do_load),
        .do_save  (do_save),
        .do_delta (do_delta),
        .stage    (stage),
        .live     (live),
        .snap     (snap)
    );

    assign tod_sec  = live.sec;
    assign tod_ns   = live.ns;
    assign snap_sec = snap.sec;
    assign snap_ns  = snap.ns;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [SEC_W-1:0]  tod_sec,
    input logic [NS_W-1:0]   tod_ns,
    input logic [SEC_W-1:0]  snap_sec,
    input logic [NS_W-1:0]   snap_ns,
    input logic              run_q,
    input logic              hold_q,
    input logic [INC_W-1:0]  inc_act
);

    logic act_wr;
    logic save_wr;

    assign act_wr  = wr_en && (wr_addr == REG_ACT);
    assign save_wr = act_wr && (wr_data[2:0] == SLOT_SAVE);

    p_ns_below_limit_r3: assert property (@(posedge clk) disable iff (rst)
        tod_ns < NS_PER_SEC);

    p_snap_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !save_wr |=> ($stable(snap_sec) && $stable(snap_ns)));

    p_snap_captures_r9: assert property (@(posedge clk) disable iff (rst)
        save_wr |=> (snap_sec == $past(tod_sec) && snap_ns == $past(tod_ns)));

    p_inc_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        !hold_q |=> $stable(inc_act));

    p_stopped_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !act_wr) |=> ($stable(tod_sec) && $stable(tod_ns)));

endmodule

bind tod_counter tod_counter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tod_sec  (tod_sec),
    .tod_ns   (tod_ns),
    .snap_sec (snap_sec),
    .snap_ns  (snap_ns),
    .run_q    (run_q),
    .hold_q   (hold_q),
    .inc_act  (inc_act)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [47:0] tod_sec, snap_sec;
    logic [29:0] tod_ns, snap_ns;

    int nchk = 0;
    int nfail = 0;

    localparam logic [63:0] NOM = 64'h304D_4873_ECAD_E305;

    always #2 clk = ~clk;

    tod_counter u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .snap_sec(snap_sec), .snap_ns(snap_ns)
    );

    typedef struct packed {
        logic [47:0] s0;
        logic [29:0] n0;
        logic [29:0] d;
        logic [47:0] es;
        logic [29:0] en;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{48'd100, 30'd500, 30'd1000, 48'd100, 30'd1500},
        '{48'd100, 30'd500, 30'd1073740824, 48'd99, 30'd999999500},
        '{48'd7, 30'd999999000, 30'd2000, 48'd8, 30'd1000},
        '{48'd7, 30'd0, 30'd1073741823, 48'd6, 30'd999999999},
        '{48'h123456789ABC, 30'd250000000, 30'd499999999, 48'h123456789ABC, 30'd749999999},
        '{48'd50, 30'd600000000, 30'd499999999, 48'd51, 30'd99999999},
        '{48'd50, 30'd400000000, 30'd573741825, 48'd49, 30'd900000001},
        '{48'd3, 30'd123, 30'd0, 48'd3, 30'd123},
        '{48'hFFFFFFFFFFFF, 30'd999999999, 30'd1, 48'd0, 30'd0}
    };

    task automatic chk(input string req, input logic [47:0] gs, input logic [47:0] es,
                       input logic [29:0] gn, input logic [29:0] en);
        nchk++;
        if (gs !== es || gn !== en) begin
            nfail++;
            $display("FAIL %s: got sec=%0d ns=%0d, expected sec=%0d ns=%0d", req, gs, gn, es, en);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [47:0] s, input logic [29:0] n);
        wr(3'd3, 32'd0);
        wr(3'd4, {16'd0, s[47:32]});
        wr(3'd5, s[31:0]);
        wr(3'd6, {2'b00, n});
        wr(3'd3, 32'd1);
        wr(3'd3, 32'd0);
    endtask

    task automatic apply_delta(input logic [29:0] d);
        wr(3'd6, {2'b00, d});
        wr(3'd3, 32'd4);
        wr(3'd3, 32'd0);
    endtask

    task automatic run_ticks(input int n, input logic [31:0] hold_bits);
        wr(3'd2, hold_bits | 32'd1);
        repeat (n - 1) @(negedge clk);
        wr(3'd2, hold_bits);
    endtask

    task automatic model(input logic [47:0] s0, input logic [29:0] n0, input int n,
                         input logic [63:0] inc, output logic [47:0] es, output logic [29:0] en);
        logic [127:0] prod;
        logic [127:0] tot;
        prod = 128'(n) * 128'(inc);
        tot  = 128'(n0) + (prod >> 59);
        es   = s0 + 48'(tot / 128'd1000000000);
        en   = 30'(tot % 128'd1000000000);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [47:0] es;
        logic [29:0] en;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 live", tod_sec, 48'd0, tod_ns, 30'd0);
        chk("R1 snap", snap_sec, 48'd0, snap_ns, 30'd0);
        repeat (20) @(negedge clk);
        chk("R1 R12 stopped after reset", tod_sec, 48'd0, tod_ns, 30'd0);

        // R10 R9 delta vectors
        for (int i = 0; i < NV; i++) begin
            set_time(VEC[i].s0, VEC[i].n0);
            apply_delta(VEC[i].d);
            wr(3'd3, 32'd2);
            chk($sformatf("R10 R9 vector %0d", i), snap_sec, VEC[i].es, snap_ns, VEC[i].en);
            wr(3'd3, 32'd0);
        end

        // R2 counting with nominal increment (R1 reset value)
        set_time(48'd0, 30'd0);
        run_ticks(1000, 32'd0);
        model(48'd0, 30'd0, 1000, NOM, es, en);
        chk("R2 R1 nominal count", tod_sec, es, tod_ns, en);

        // R3 rollover
        set_time(48'd5, 30'd999999990);
        run_ticks(2, 32'd0);
        model(48'd5, 30'd999999990, 2, NOM, es, en);
        chk("R3 second rollover", tod_sec, es, tod_ns, en);

        // R12 stopped
        repeat (10) @(negedge clk);
        chk("R12 frozen while stopped", tod_sec, es, tod_ns, en);

        // R8 negative-coded load
        set_time(48'd10, 30'h3FFFFFF5);
        chk("R8 negative load", tod_sec, 48'd9, tod_ns, 30'd999999989);

        // R7 illegal ns load ignored
        set_time(48'd10, 30'd1000000000);
        chk("R7 illegal load ignored", tod_sec, 48'd9, tod_ns, 30'd999999989);

        // R6 load/delta after non-idle ignored
        set_time(48'd20, 30'd20);
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd30);
        wr(3'd6, 32'd30);
        wr(3'd3, 32'd1);
        chk("R6 load after save ignored", tod_sec, 48'd20, tod_ns, 30'd20);
        wr(3'd3, 32'd4);
        chk("R6 delta after save ignored", tod_sec, 48'd20, tod_ns, 30'd20);
        wr(3'd3, 32'd0);
        wr(3'd3, 32'd3);
        chk("R5 reserved code no effect", tod_sec, 48'd20, tod_ns, 30'd20);
        wr(3'd3, 32'd1);
        chk("R5 R6 R7 load accepted after idle", tod_sec, 48'd30, tod_ns, 30'd30);
        wr(3'd6, 32'd5);
        wr(3'd3, 32'd4);
        chk("R6 delta after load ignored", tod_sec, 48'd30, tod_ns, 30'd30);
        wr(3'd3, 32'd0);

        // R11 out-of-range deltas
        apply_delta(30'd500000000);
        chk("R11 +half second ignored", tod_sec, 48'd30, tod_ns, 30'd30);
        apply_delta(30'd573741824);
        chk("R11 -half second ignored", tod_sec, 48'd30, tod_ns, 30'd30);

        // R4 increment programming
        wr(3'd2, 32'd2);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'h0800_0000);
        wr(3'd2, 32'd0);
        set_time(48'd0, 30'd0);
        run_ticks(10, 32'd0);
        chk("R4 one ns increment applied", tod_sec, 48'd0, tod_ns, 30'd10);
        wr(3'd1, 32'h1000_0000);
        set_time(48'd0, 30'd0);
        run_ticks(10, 32'd0);
        chk("R4 write without hold ignored", tod_sec, 48'd0, tod_ns, 30'd10);
        wr(3'd2, 32'd2);
        wr(3'd1, 32'h1000_0000);
        set_time(48'd0, 30'd0);
        run_ticks(10, 32'd2);
        chk("R4 old increment while held", tod_sec, 48'd0, tod_ns, 30'd10);
        wr(3'd2, 32'd0);
        set_time(48'd0, 30'd0);
        run_ticks(10, 32'd0);
        chk("R4 new increment after release", tod_sec, 48'd0, tod_ns, 30'd20);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule